// File: doc/BRIEF.md
# Windowed Zero-Crossing Mute Controller

This block sits in a digital audio path and switches a mute gate for a left and a right channel of signed PCM samples. A mute or unmute request is never applied straight away. Each channel keeps its previous gate state until one of its own samples has a magnitude inside a narrow band around zero, and only then adopts the request. The gate therefore opens or closes near a zero crossing, with no audible step. The width of that band is picked by a 2-bit code, and each code step halves the band.

The same per-channel window comparators feed a pause detector. The detector counts consecutive valid samples in which both channels sit inside the window. It restarts from zero on any sample that leaves the window, and it raises an active-low pause flag once the count reaches a programmable limit. A disable input stops both functions: the gates freeze, the integrator clears and the pause flag reads "no pause".

Samples enter on a valid/ready stream port. The block accepts one sample pair on every cycle in which `s_valid` is high, and it never applies back-pressure. `s_ready` is held high so that an upstream stage can connect without special handling. The gate outputs are meant to drive a downstream multiplier or select stage.

Top module: `zc_mute_ctrl`

## Requirements
- R1: A sample is inside the window when its magnitude is strictly below 2048 >> code, where `win_code` = 2'b00 gives 2048, 2'b01 gives 1024, 2'b10 gives 512 and 2'b11 gives 256 (16-bit scale).
- R2: A channel gate (1 = muted) takes the value of `mute_req` only on an accepted sample, with `det_off` low, whose magnitude on that channel is inside the window. The new value appears on the cycle after the accepting edge. Otherwise the gate keeps its value.
- R3: The left and right gates are decided separately, each from its own channel's sample only.
- R4: `zm_status` is 1 while at least one channel gate is muted, and 0 when both are open.
- R5: While `det_off` is 1, both gates hold their state, the pause integrator is cleared and `pause_n` reads 1, whatever the samples are.
- R6: On each accepted sample with `det_off` low, the pause count goes up by one (and saturates at its maximum) if both channels are inside the window, and it goes back to zero otherwise. `pause_n` becomes 0 on the next cycle when the updated count is nonzero and at least `pause_limit`, and 1 otherwise.
- R7: Cycles with `s_valid` low and `det_off` low change neither the gates nor `pause_n`.
- R8: After reset both gates are 0, `zm_status` is 0, `pause_n` is 1, and `s_ready` is 1 at all times.
- R9: The most negative sample value, -32768, counts as magnitude 32768 and always lies outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Always 1; the block never stalls |
| s_left | input | 16 | Left channel sample, two's complement |
| s_right | input | 16 | Right channel sample, two's complement |
| mute_req | input | 1 | Requested gate state: 1 mute, 0 unmute |
| win_code | input | 2 | Window half-width select, 00 widest, 11 narrowest |
| det_off | input | 1 | Stops comparators, freezes gates, clears pause integrator |
| pause_limit | input | 16 | Pause count threshold |
| gate_left | output | 1 | Left channel mute gate, 1 = muted |
| gate_right | output | 1 | Right channel mute gate, 1 = muted |
| zm_status | output | 1 | 1 while either channel is muted |
| pause_n | output | 1 | 0 = pause detected, 1 = no pause |

## Verification
The stimulus places samples one LSB on either side of the threshold for the widest and the narrowest codes. This shows whether the comparison is strict and whether the code-to-width mapping is right. Loud samples sent with a pending request show that the change is held back, and pairs with one quiet and one loud channel show that the two gates are decided separately. A run of quiet samples against a small limit, ended by a single loud sample, shows the exact sample on which the pause flag asserts and that it clears at once. Idle cycles, the disable input and the value -32768 are each sent with quiet-looking data, so that any gate or pause change they cause shows up at the outputs.

// File: rtl/zcm_pkg.sv
package zcm_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_L   = 0;
  localparam int CH_R   = 1;

  typedef enum logic [1:0] {
    WIN_WIDE   = 2'b00,
    WIN_MID    = 2'b01,
    WIN_NARROW = 2'b10,
    WIN_TIGHT  = 2'b11
  } win_code_e;
endpackage

// File: rtl/zcm_window_cmp.sv
module zcm_window_cmp #(
  parameter int SAMPLE_W   = 16,
  parameter int BASE_SHIFT = 11
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [1:0]                 win_code,
  output logic                       in_win
);
  localparam int MAG_W = SAMPLE_W + 1;

  logic [MAG_W-1:0] ext;
  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] thr;

  always_comb begin
    ext = {sample[SAMPLE_W-1], sample};
    // magnitude is one bit wider so the most negative code stays large
    mag = sample[SAMPLE_W-1] ? (~ext + MAG_W'(1)) : ext;
    thr = (MAG_W'(1) << BASE_SHIFT) >> win_code;
    in_win = (mag < thr);
  end
endmodule

// File: rtl/zcm_gate.sv
module zcm_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic in_win,
  input  logic req,
  output logic gate_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gate_q <= 1'b0;
    else if (sample_en && in_win)
      gate_q <= req;
  end
endmodule

// File: rtl/zcm_pause_integ.sv
module zcm_pause_integ #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             off,
  input  logic             sample_en,
  input  logic             all_in,
  input  logic [CNT_W-1:0] limit,
  output logic             pause_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             det_q;

  always_comb begin
    if (!all_in)
      cnt_nxt = '0;
    else if (cnt_q == CNT_MAX)
      cnt_nxt = cnt_q;
    else
      cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      det_q <= 1'b0;
    end else if (off) begin
      cnt_q <= '0;
      det_q <= 1'b0;
    end else if (sample_en) begin
      cnt_q <= cnt_nxt;
      det_q <= (cnt_nxt != '0) && (cnt_nxt >= limit);
    end
  end

  assign pause_n = ~det_q;
endmodule

// File: rtl/zc_mute_ctrl.sv
module zc_mute_ctrl #(
  parameter int SAMPLE_W   = 16,
  parameter int BASE_SHIFT = 11,
  parameter int CNT_W      = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic signed [SAMPLE_W-1:0] s_left,
  input  logic signed [SAMPLE_W-1:0] s_right,
  input  logic                       mute_req,
  input  logic [1:0]                 win_code,
  input  logic                       det_off,
  input  logic [CNT_W-1:0]           pause_limit,
  output logic                       gate_left,
  output logic                       gate_right,
  output logic                       zm_status,
  output logic                       pause_n
);
  import zcm_pkg::*;

  logic signed [SAMPLE_W-1:0] samp [NUM_CH];
  logic [NUM_CH-1:0]          in_win;
  logic [NUM_CH-1:0]          gate_q;
  logic                       sample_en;

  assign s_ready   = 1'b1;
  assign sample_en = s_valid && !det_off;
  assign samp[CH_L] = s_left;
  assign samp[CH_R] = s_right;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    zcm_window_cmp #(
      .SAMPLE_W  (SAMPLE_W),
      .BASE_SHIFT(BASE_SHIFT)
    ) u_cmp (
      .sample  (samp[ch]),
      .win_code(win_code),
      .in_win  (in_win[ch])
    );

    zcm_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_en(sample_en),
      .in_win   (in_win[ch]),
      .req      (mute_req),
      .gate_q   (gate_q[ch])
    );
  end

  zcm_pause_integ #(
    .CNT_W(CNT_W)
  ) u_pause (
    .clk      (clk),
    .rst_n    (rst_n),
    .off      (det_off),
    .sample_en(sample_en),
    .all_in   (&in_win),
    .limit    (pause_limit),
    .pause_n  (pause_n)
  );

  assign gate_left  = gate_q[CH_L];
  assign gate_right = gate_q[CH_R];
  assign zm_status  = |gate_q;
endmodule

// File: rtl/zcm_checker.sv
module zcm_checker #(
  parameter int SAMPLE_W   = 16,
  parameter int BASE_SHIFT = 11,
  parameter int CNT_W      = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       s_valid,
  input logic signed [SAMPLE_W-1:0] s_left,
  input logic signed [SAMPLE_W-1:0] s_right,
  input logic                       mute_req,
  input logic [1:0]                 win_code,
  input logic                       det_off,
  input logic                       gate_left,
  input logic                       gate_right,
  input logic                       zm_status,
  input logic                       pause_n
);
  localparam int MW = SAMPLE_W + 1;
  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  int  l_abs, r_abs, lim;
  logic l_in, r_in;

  always_comb begin
    l_abs = (s_left  < 0) ? -int'(s_left)  : int'(s_left);
    r_abs = (s_right < 0) ? -int'(s_right) : int'(s_right);
    lim   = (1 << BASE_SHIFT) >> win_code;
    l_in  = (l_abs < lim);
    r_in  = (r_abs < lim);
  end

  AST_GATE_L_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_left) |-> $past(s_valid && !det_off)); // R2
  AST_GATE_L_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_left) |-> $past(l_in)); // R1
  AST_GATE_R_OWN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_right) |-> $past(r_in)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && !det_off) |=> ($stable(gate_left) && $stable(gate_right) && $stable(pause_n))); // R7
  AST_OFF_NO_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    det_off |=> pause_n); // R5
  AST_OFF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    det_off |=> ($stable(gate_left) && $stable(gate_right))); // R5
  AST_OUT_CLEARS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !det_off && !(l_in && r_in)) |=> pause_n); // R6
  AST_ZM_RISE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zm_status) |-> $past(mute_req)); // R4
  AST_MOST_NEG_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_left == MOST_NEG) |=> $stable(gate_left)); // R9
endmodule

bind zc_mute_ctrl zcm_checker #(
  .SAMPLE_W  (SAMPLE_W),
  .BASE_SHIFT(BASE_SHIFT),
  .CNT_W     (CNT_W)
) u_zcm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_left    (s_left),
  .s_right   (s_right),
  .mute_req  (mute_req),
  .win_code  (win_code),
  .det_off   (det_off),
  .gate_left (gate_left),
  .gate_right(gate_right),
  .zm_status (zm_status),
  .pause_n   (pause_n)
);

// File: tb/tb_zc_mute_ctrl.sv
`timescale 1ns/1ps
module tb_zc_mute_ctrl;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               s_valid = 1'b0;
  logic               s_ready;
  logic signed [15:0] s_left = '0;
  logic signed [15:0] s_right = '0;
  logic               mute_req = 1'b0;
  logic [1:0]         win_code = 2'b00;
  logic               det_off = 1'b0;
  logic [15:0]        pause_limit = 16'd3;
  logic               gate_left, gate_right, zm_status, pause_n;

  always #2.5 clk = ~clk;

  zc_mute_ctrl dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .mute_req(mute_req),
    .win_code(win_code), .det_off(det_off), .pause_limit(pause_limit),
    .gate_left(gate_left), .gate_right(gate_right),
    .zm_status(zm_status), .pause_n(pause_n)
  );

  typedef struct {
    logic  gl, gr, zm, pn;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // reference model state
  bit m_gl = 0, m_gr = 0, m_det = 0;
  int m_cnt = 0;

  function automatic bit inside_win(int v, logic [1:0] code);
    int a = (v < 0) ? -v : v;
    return a < (2048 >> code);
  endfunction

  task automatic check1(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic send(int l, int r, bit req, logic [1:0] code, bit off, bit vld, string tag);
    exp_t e;
    bit li, ri;
    @(negedge clk);
    s_left = 16'(l); s_right = 16'(r); mute_req = req;
    win_code = code; det_off = off; s_valid = vld;
    li = inside_win(l, code);
    ri = inside_win(r, code);
    if (off) begin
      m_cnt = 0; m_det = 0;
    end else if (vld) begin
      if (li) m_gl = req;
      if (ri) m_gr = req;
      if (li && ri) m_cnt = (m_cnt == 65535) ? m_cnt : m_cnt + 1;
      else m_cnt = 0;
      m_det = (m_cnt != 0) && (m_cnt >= int'(pause_limit));
    end
    e.gl = m_gl; e.gr = m_gr; e.zm = m_gl | m_gr; e.pn = ~m_det; e.tag = tag;
    @(posedge clk);
    #1;
    q.push_back(e);
  endtask

  // monitor: compare each expected item one half cycle after its edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check1(e.tag, "gate_left",  gate_left,  e.gl);
      check1(e.tag, "gate_right", gate_right, e.gr);
      check1({e.tag, "/R4"}, "zm_status", zm_status, e.zm);
      check1(e.tag, "pause_n",    pause_n,    e.pn);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check1("R8", "gate_left", gate_left, 1'b0);
    check1("R8", "gate_right", gate_right, 1'b0);
    check1("R8", "zm_status", zm_status, 1'b0);
    check1("R8", "pause_n", pause_n, 1'b1);
    check1("R8", "s_ready", s_ready, 1'b1);
    rst_n = 1'b1;
    pause_limit = 16'd50;

    // R1: boundary on widest window, strict compare
    send( 2047, -2047, 1, 2'b00, 0, 1, "R1");
    send( 2048, -2048, 0, 2'b00, 0, 1, "R1");
    // R1/R3: narrowest window, left just in, right just out
    send(  255,   256, 0, 2'b11, 0, 1, "R1");
    send( -255,  -256, 0, 2'b11, 0, 1, "R3");
    // R2: loud samples defer the request
    send(20000, -20000, 1, 2'b01, 0, 1, "R2");
    send( 1500,  -900, 1, 2'b01, 0, 1, "R2");
    send( 1023,  1023, 1, 2'b01, 0, 1, "R2");
    // R3: release only the right channel
    send(30000,   100, 0, 2'b10, 0, 1, "R3");
    send(  511, -9000, 1, 2'b10, 0, 1, "R3");
    // R9: most negative value never in window
    send(-32768,  5000, 0, 2'b00, 0, 1, "R9");
    // R7: idle cycles ignore data and request
    send(    0,     0, 0, 2'b00, 0, 0, "R7");
    send(    0,     0, 0, 2'b11, 0, 0, "R7");
    send(    0,     0, 0, 2'b00, 0, 1, "R4");

    // R6: pause integrator with limit 3
    pause_limit = 16'd3;
    send(   10,   -10, 0, 2'b00, 0, 1, "R6");
    send(   20,   -20, 0, 2'b00, 0, 1, "R6");
    send(    0,     0, 0, 2'b00, 0, 1, "R6");
    send(    5,     5, 0, 2'b00, 0, 1, "R6");
    send(    5,     5, 0, 2'b00, 0, 0, "R7");
    send(  100,  4000, 0, 2'b00, 0, 1, "R6");
    send(    1,     1, 0, 2'b00, 0, 1, "R6");
    send(    1,     1, 0, 2'b00, 0, 1, "R6");
    send(    1,     1, 0, 2'b00, 0, 1, "R6");

    // R5: disable freezes gates and forces no pause
    send(    0,     0, 1, 2'b00, 1, 1, "R5");
    send(    0,     0, 1, 2'b00, 1, 1, "R5");
    send(    0,     0, 1, 2'b00, 1, 0, "R5");
    // after re-enable the integrator restarts from zero
    send(    0,     0, 1, 2'b00, 0, 1, "R5");
    send(    0,     0, 1, 2'b00, 0, 1, "R6");
    send(    0,     0, 0, 2'b00, 0, 1, "R6");

    @(negedge clk);
    s_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule